// File: doc/BRIEF.md
# Stack Frame Sequencer for Calls, Breaks and Interrupts

This block moves stack frames between an 8-bit CPU core and its byte-wide data memory. The core presents a command together with the current stack pointer, program counter, instruction length, status word and a 16-bit register pair. The sequencer then transfers one byte per clock, either saving or restoring bytes. When it finishes, it reports the new stack pointer and whichever of PC, status word or pair the command restores.

Saving commands grow the stack downward. A subroutine call saves a two-byte return address. A software break or a hardware interrupt saves three bytes, with the status word placed at the highest address. Register-pair and status-word pushes save two bytes and one byte. Restoring commands mirror these layouts upward from the stack pointer. Once the status word has been saved on break or interrupt entry, the sequencer presents the status word with its interrupt-enable bit cleared. Decoding instructions, arbitrating interrupts and the memory itself belong to other blocks.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset, busy, done, mem_we and mem_re are 0. sp_out equals parameter SP_RESET (default 16'hFE20), and pc_out, psw_out and pair_out are 0.
- R2: Command codes are 1 call, 2 break, 3 interrupt, 4 push pair, 5 push status, 6 return, 7 return from interrupt, 8 return from break, 9 pop pair and 10 pop status. A command is accepted at a clock edge where busy is 0, cmd_valid is 1 and the code is one of these. Busy is 1 from the next cycle on. Byte k of the frame (k = 0, 1, 2) is transferred in cycle k after acceptance, with exactly one of mem_we and mem_re high. mem_rdata is taken in the same cycle as the read address.
- R3: A call writes the high byte of pc_in+ilen to sp_in-1 and its low byte to sp_in-2. The resulting sp_out is sp_in-2.
- R4: A break writes psw_in to sp_in-1, the high byte of pc_in+1 to sp_in-2 and its low byte to sp_in-3. The resulting sp_out is sp_in-3.
- R5: An interrupt writes the same three-byte frame as R4, but saves pc_in unchanged. After a break or an interrupt, psw_out equals psw_in with bit IE_BIT (default 7) cleared. The bit is still set in the saved byte.
- R6: Push pair writes pair_in[15:8] to sp_in-1 and pair_in[7:0] to sp_in-2, and gives sp_out = sp_in-2. Push status writes psw_in to sp_in-1 and gives sp_out = sp_in-1.
- R7: A return reads the PC low byte from sp_in and the PC high byte from sp_in+1, and gives sp_out = sp_in+2.
- R8: Return from interrupt and return from break read PC low from sp_in, PC high from sp_in+1 and the status word from sp_in+2. Both give sp_out = sp_in+3.
- R9: Pop pair reads pair_out low from sp_in and high from sp_in+1, giving sp_out = sp_in+2. Pop status reads psw_out from sp_in, giving sp_out = sp_in+1. Outputs that a command does not restore keep their values.
- R10: done is high for exactly the one cycle after the last byte transfer. In that same cycle busy is still 1, and sp_out and the restored outputs already hold their new values. sp_out changes at no other time.
- R11: While busy is 1, cmd_valid is ignored. An undefined code (0 or 11 to 15) is ignored when idle. An ignored command causes no memory access, no busy and no change of any output.
- R12: Stack address arithmetic wraps modulo 2^16 for both addresses and sp_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 4 | Command code (see R2) |
| sp_in | input | 16 | Stack pointer before the command |
| pc_in | input | 16 | Program counter of the current instruction |
| ilen | input | 2 | Length in bytes of the call instruction |
| psw_in | input | 8 | Status word to save |
| pair_in | input | 16 | Register pair to save |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| sp_out | output | 16 | Stack pointer after the last command |
| pc_out | output | 16 | Restored program counter |
| psw_out | output | 8 | Restored or updated status word |
| pair_out | output | 16 | Restored register pair |

## Verification
The bench runs directed frames for every command code with distinct byte values in every field, so that a swapped high and low byte or a misplaced status byte shows up as a wrong write address or data. Stack pointers near 0000 and FFFF separate correct modulo wrap from sign or carry errors. Constrained random sequences mix saves and restores over random stack pointers and memory contents. These show whether outputs that a command does not restore are truly left alone. Disturbing commands issued during a sequence, and undefined codes issued while idle, show whether acceptance is gated correctly.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   localparam int FRAME_MAX = 3;
   localparam int IDX_W     = $clog2(FRAME_MAX + 1);

   typedef enum logic [3:0] {
      OP_NONE  = 4'd0,
      OP_CALL  = 4'd1,
      OP_BRK   = 4'd2,
      OP_IRQ   = 4'd3,
      OP_PSHP  = 4'd4,
      OP_PSHS  = 4'd5,
      OP_RET   = 4'd6,
      OP_RETI  = 4'd7,
      OP_RETB  = 4'd8,
      OP_POPP  = 4'd9,
      OP_POPS  = 4'd10
   } sfs_op_e;

   typedef enum logic [2:0] {
      SEL_PCL,
      SEL_PCH,
      SEL_PSW,
      SEL_PRL,
      SEL_PRH
   } sfs_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_XFER,
      ST_FIN
   } sfs_state_e;

   function automatic logic op_known(input logic [3:0] c);
      return (c >= 4'd1) && (c <= 4'd10);
   endfunction

   function automatic logic op_saves(input logic [3:0] c);
      return (c >= 4'd1) && (c <= 4'd5);
   endfunction

   function automatic logic [IDX_W-1:0] op_len(input logic [3:0] c);
      case (c)
         OP_BRK, OP_IRQ, OP_RETI, OP_RETB: return IDX_W'(3);
         OP_PSHS, OP_POPS:                 return IDX_W'(1);
         default:                          return IDX_W'(2);
      endcase
   endfunction

   // Byte chosen for slot k; saves count downward from SP-1, restores upward from SP.
   function automatic sfs_sel_e op_pick(input logic [3:0] c, input logic [IDX_W-1:0] k);
      case (c)
         OP_CALL:         return (k == 0) ? SEL_PCH : SEL_PCL;
         OP_BRK, OP_IRQ:  return (k == 0) ? SEL_PSW : ((k == 1) ? SEL_PCH : SEL_PCL);
         OP_PSHP:         return (k == 0) ? SEL_PRH : SEL_PRL;
         OP_PSHS, OP_POPS: return SEL_PSW;
         OP_POPP:         return (k == 0) ? SEL_PRL : SEL_PRH;
         default:         return (k == 0) ? SEL_PCL : ((k == 1) ? SEL_PCH : SEL_PSW);
      endcase
   endfunction

endpackage

// File: rtl/sfs_frame_plan.sv
module sfs_frame_plan
   import sfs_pkg::*;
(
   input  logic [3:0]       op,
   input  logic [IDX_W-1:0] slot,
   output sfs_sel_e         sel,
   output logic             is_save,
   output logic             is_last,
   output logic [IDX_W-1:0] len
);
   always_comb begin
      len     = op_len(op);
      is_save = op_saves(op);
      sel     = op_pick(op, slot);
      is_last = (slot == len - IDX_W'(1));
   end
endmodule

// File: rtl/sfs_addr_gen.sv
module sfs_addr_gen #(
   parameter int AW    = 16,
   parameter int IDX_W = 2
) (
   input  logic [AW-1:0]    base,
   input  logic [IDX_W-1:0] slot,
   input  logic [IDX_W-1:0] len,
   input  logic             is_save,
   output logic [AW-1:0]    addr,
   output logic [AW-1:0]    sp_next
);
   localparam logic [AW-1:0] ONE = AW'(1);

   always_comb begin
      if (is_save) begin
         addr    = base - ONE - AW'(slot);
         sp_next = base - AW'(len);
      end else begin
         addr    = base + AW'(slot);
         sp_next = base + AW'(len);
      end
   end
endmodule

// File: rtl/sfs_restore.sv
module sfs_restore
   import sfs_pkg::*;
#(
   parameter int DW     = 8,
   parameter int IE_BIT = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_stb,
   input  sfs_sel_e        sel,
   input  logic [DW-1:0]   rdata,
   input  logic            clr_ie,
   input  logic [DW-1:0]   psw_src,
   output logic [2*DW-1:0] pc_q,
   output logic [DW-1:0]   psw_q,
   output logic [2*DW-1:0] pair_q
);
   localparam int LANES = 2;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      localparam sfs_sel_e PC_SEL = (ln == 0) ? SEL_PCL : SEL_PCH;
      localparam sfs_sel_e PR_SEL = (ln == 0) ? SEL_PRL : SEL_PRH;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_q[ln*DW +: DW]   <= '0;
            pair_q[ln*DW +: DW] <= '0;
         end else if (rd_stb) begin
            if (sel == PC_SEL) pc_q[ln*DW +: DW]   <= rdata;
            if (sel == PR_SEL) pair_q[ln*DW +: DW] <= rdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psw_q <= '0;
      end else if (rd_stb && sel == SEL_PSW) begin
         psw_q <= rdata;
      end else if (clr_ie) begin
         psw_q <= psw_src & ~(DW'(1) << IE_BIT);
      end
   end
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
   import sfs_pkg::*;
#(
   parameter int               DW       = 8,
   parameter int               AW       = 16,
   parameter int               LEN_W    = 2,
   parameter int               IE_BIT   = 7,
   parameter logic [AW-1:0]    SP_RESET = 16'hFE20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd,
   input  logic [AW-1:0]    sp_in,
   input  logic [AW-1:0]    pc_in,
   input  logic [LEN_W-1:0] ilen,
   input  logic [DW-1:0]    psw_in,
   input  logic [AW-1:0]    pair_in,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_we,
   output logic [DW-1:0]    mem_wdata,
   output logic             mem_re,
   input  logic [DW-1:0]    mem_rdata,
   output logic             busy,
   output logic             done,
   output logic [AW-1:0]    sp_out,
   output logic [AW-1:0]    pc_out,
   output logic [DW-1:0]    psw_out,
   output logic [AW-1:0]    pair_out
);
   if (AW != 2 * DW) begin : g_bad_width
      $error("stack_frame_seq: AW must be twice DW");
   end
   if (IE_BIT < 0 || IE_BIT >= DW) begin : g_bad_ie
      $error("stack_frame_seq: IE_BIT outside the status word");
   end

   sfs_state_e       state;
   logic [IDX_W-1:0] slot;
   logic [3:0]       op_q;
   logic [AW-1:0]    base_q;
   logic [AW-1:0]    rpc_q;
   logic [DW-1:0]    psw_q;
   logic [AW-1:0]    pair_q;

   sfs_sel_e         sel;
   logic             is_save;
   logic             is_last;
   logic [IDX_W-1:0] len;
   logic [AW-1:0]    sp_next;
   logic             xfer;
   logic             accept;
   logic             clr_ie;
   logic [AW-1:0]    rpc_new;

   assign xfer   = (state == ST_XFER);
   assign accept = (state == ST_IDLE) && cmd_valid && op_known(cmd);
   assign busy   = (state != ST_IDLE);
   assign done   = (state == ST_FIN);

   always_comb begin
      case (cmd)
         OP_CALL: rpc_new = pc_in + AW'(ilen);
         OP_BRK:  rpc_new = pc_in + AW'(1);
         default: rpc_new = pc_in;
      endcase
   end

   sfs_frame_plan u_plan (
      .op      (op_q),
      .slot    (slot),
      .sel     (sel),
      .is_save (is_save),
      .is_last (is_last),
      .len     (len)
   );

   sfs_addr_gen #(.AW(AW), .IDX_W(IDX_W)) u_addr (
      .base    (base_q),
      .slot    (slot),
      .len     (len),
      .is_save (is_save),
      .addr    (mem_addr),
      .sp_next (sp_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         slot   <= '0;
         op_q   <= OP_NONE;
         base_q <= '0;
         rpc_q  <= '0;
         psw_q  <= '0;
         pair_q <= '0;
         sp_out <= SP_RESET;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               state  <= ST_XFER;
               slot   <= '0;
               op_q   <= cmd;
               base_q <= sp_in;
               rpc_q  <= rpc_new;
               psw_q  <= psw_in;
               pair_q <= pair_in;
            end
            ST_XFER: if (is_last) begin
               state  <= ST_FIN;
               sp_out <= sp_next;
            end else begin
               slot <= slot + IDX_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_we = xfer && is_save;
   assign mem_re = xfer && !is_save;

   always_comb begin
      case (sel)
         SEL_PCH: mem_wdata = rpc_q[AW-1:DW];
         SEL_PCL: mem_wdata = rpc_q[DW-1:0];
         SEL_PRH: mem_wdata = pair_q[AW-1:DW];
         SEL_PRL: mem_wdata = pair_q[DW-1:0];
         default: mem_wdata = psw_q;
      endcase
   end

   assign clr_ie = xfer && is_last && (op_q == OP_BRK || op_q == OP_IRQ);

   sfs_restore #(.DW(DW), .IE_BIT(IE_BIT)) u_rest (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_stb  (mem_re),
      .sel     (sel),
      .rdata   (mem_rdata),
      .clr_ie  (clr_ie),
      .psw_src (psw_q),
      .pc_q    (pc_out),
      .psw_q   (psw_out),
      .pair_q  (pair_out)
   );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
   import sfs_pkg::*;
#(
   parameter int DW     = 8,
   parameter int AW     = 16,
   parameter int IE_BIT = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic [3:0]    cmd,
   input logic          mem_we,
   input logic          mem_re,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] sp_out,
   input logic [AW-1:0] pc_out,
   input logic [DW-1:0] psw_out
);
   logic       armed;
   logic [3:0] cap_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         cap_op <= 4'd0;
      end else begin
         armed <= 1'b1;
         if (!busy && cmd_valid && op_known(cmd)) cap_op <= cmd;
      end
   end

   p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && op_known(cmd)) |=> busy);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   p_sp_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && sp_out != $past(sp_out)) |-> done);

   p_pc_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pc_out != $past(pc_out)) |-> $past(mem_re));

   p_ie_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (cap_op == 4'd2 || cap_op == 4'd3)) |-> !psw_out[IE_BIT]);
endmodule

bind stack_frame_seq sfs_checker #(.DW(DW), .AW(AW), .IE_BIT(IE_BIT)) u_sfs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd       (cmd),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .busy      (busy),
   .done      (done),
   .sp_out    (sp_out),
   .pc_out    (pc_out),
   .psw_out   (psw_out)
);

// File: tb/test_stack_frame_seq.sv
module test_stack_frame_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd = 4'd0;
   logic [15:0] sp_in = 16'h0;
   logic [15:0] pc_in = 16'h0;
   logic [1:0]  ilen = 2'd0;
   logic [7:0]  psw_in = 8'h0;
   logic [15:0] pair_in = 16'h0;
   logic [15:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic        mem_re;
   logic [7:0]  mem_rdata;
   logic        busy, done;
   logic [15:0] sp_out, pc_out, pair_out;
   logic [7:0]  psw_out;

   int errors = 0;
   int checks = 0;
   logic [7:0]  mem [0:255];
   logic [15:0] m_pc = 16'h0, m_pair = 16'h0, m_sp = 16'hFE20;
   logic [7:0]  m_psw = 8'h0;

   always #10 clk = ~clk;

   stack_frame_seq i_stack_frame_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .sp_in(sp_in), .pc_in(pc_in), .ilen(ilen), .psw_in(psw_in),
      .pair_in(pair_in), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .sp_out(sp_out), .pc_out(pc_out),
      .psw_out(psw_out), .pair_out(pair_out)
   );

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int blen(input int c);
      if (c == 2 || c == 3 || c == 7 || c == 8) return 3;
      if (c == 5 || c == 10) return 1;
      return 2;
   endfunction

   function automatic string tag(input int c);
      case (c)
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4, 5: return "R6";
         6: return "R7";
         7, 8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic run_cmd(input int c, input logic [15:0] sp, input logic [15:0] pc,
                          input logic [1:0] il, input logic [7:0] ps,
                          input logic [15:0] pr, input bit disturb, input string rq);
      int n;
      bit save;
      logic [15:0] rpc;
      logic [7:0]  wb [3];
      logic [7:0]  rd [3];
      logic [15:0] e_sp;
      n = blen(c);
      save = (c <= 5);
      rpc = (c == 1) ? pc + 16'(il) : (c == 2) ? pc + 16'd1 : pc;
      case (c)
         1: begin wb[0] = rpc[15:8]; wb[1] = rpc[7:0]; wb[2] = 8'h0; end
         2, 3: begin wb[0] = ps; wb[1] = rpc[15:8]; wb[2] = rpc[7:0]; end
         4: begin wb[0] = pr[15:8]; wb[1] = pr[7:0]; wb[2] = 8'h0; end
         default: begin wb[0] = ps; wb[1] = 8'h0; wb[2] = 8'h0; end
      endcase
      for (int k = 0; k < 3; k++) begin
         logic [15:0] a;
         a = sp + 16'(k);
         rd[k] = mem[a[7:0]];
      end
      e_sp = save ? sp - 16'(n) : sp + 16'(n);
      case (c)
         2, 3: m_psw = ps & 8'h7F;
         6: m_pc = {rd[1], rd[0]};
         7, 8: begin m_pc = {rd[1], rd[0]}; m_psw = rd[2]; end
         9: m_pair = {rd[1], rd[0]};
         10: m_psw = rd[0];
         default: ;
      endcase
      m_sp = e_sp;
      cmd_valid = 1'b1; cmd = 4'(c); sp_in = sp; pc_in = pc; ilen = il;
      psw_in = ps; pair_in = pr;
      @(negedge clk);
      if (disturb) begin
         cmd = 4'd6; sp_in = sp ^ 16'h5555; psw_in = ~ps; pair_in = ~pr;
      end else begin
         cmd_valid = 1'b0;
      end
      chk(busy === 1'b1, "R2", "busy after accept", 32'(busy), 1);
      for (int k = 0; k < n; k++) begin
         logic [15:0] ea;
         ea = save ? sp - 16'd1 - 16'(k) : sp + 16'(k);
         if (save)
            chk(mem_we === 1'b1 && mem_re === 1'b0 && mem_addr === ea && mem_wdata === wb[k],
                tag(c), $sformatf("write slot %0d addr/data", k),
                {mem_we, mem_re, 6'd0, mem_wdata, mem_addr},
                {8'h80, wb[k], ea});
         else
            chk(mem_re === 1'b1 && mem_we === 1'b0 && mem_addr === ea,
                tag(c), $sformatf("read slot %0d addr", k),
                {15'd0, mem_re, mem_addr}, {15'd1, ea});
         if (rq != "") chk(mem_addr === ea, rq, "wrapped address", 32'(mem_addr), 32'(ea));
         @(negedge clk);
      end
      if (disturb) cmd_valid = 1'b0;
      chk(done === 1'b1 && busy === 1'b1, "R10", "done after last byte", {busy, done}, 2'b11);
      chk(sp_out === e_sp, tag(c), "sp_out", 32'(sp_out), 32'(e_sp));
      if (rq != "") chk(sp_out === e_sp, rq, "wrapped sp_out", 32'(sp_out), 32'(e_sp));
      chk(pc_out === m_pc, tag(c), "pc_out", 32'(pc_out), 32'(m_pc));
      chk(psw_out === m_psw, (c == 2 || c == 3) ? "R5" : tag(c), "psw_out",
          32'(psw_out), 32'(m_psw));
      chk(pair_out === m_pair, tag(c), "pair_out", 32'(pair_out), 32'(m_pair));
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R10", "done single cycle", {busy, done}, 0);
      if (disturb)
         chk(mem_we === 1'b0 && mem_re === 1'b0 && sp_out === e_sp, "R11",
             "command during busy ignored", {mem_we, mem_re, sp_out}, {2'b00, e_sp});
   endtask

   task automatic try_bad(input logic [3:0] code);
      logic [15:0] sp0;
      sp0 = sp_out;
      cmd_valid = 1'b1; cmd = code; sp_in = 16'h1234;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy === 1'b0 && mem_we === 1'b0 && mem_re === 1'b0, "R11",
          "undefined code ignored", {busy, mem_we, mem_re}, 0);
      @(negedge clk);
      chk(done === 1'b0 && sp_out === sp0 && pc_out === m_pc && psw_out === m_psw
          && pair_out === m_pair, "R11", "outputs unchanged", 32'(sp_out), 32'(sp0));
   endtask

   initial begin
      #4000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd20240611;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && mem_we === 1'b0 && mem_re === 1'b0,
          "R1", "reset strobes", {busy, done, mem_we, mem_re}, 0);
      chk(sp_out === 16'hFE20 && pc_out === 16'h0 && psw_out === 8'h0 && pair_out === 16'h0,
          "R1", "reset outputs", 32'(sp_out), 32'hFE20);
      rst_n = 1'b1;
      @(negedge clk);

      run_cmd(1, 16'hFE20, 16'h1234, 2'd3, 8'h85, 16'hA55A, 0, "");
      run_cmd(2, 16'hFE1E, 16'h2345, 2'd1, 8'hC3, 16'h0102, 0, "");
      run_cmd(3, 16'hFE1B, 16'h40FF, 2'd2, 8'h81, 16'h0304, 0, "");
      run_cmd(4, 16'hFE18, 16'h0000, 2'd1, 8'h11, 16'hBEEF, 0, "");
      run_cmd(5, 16'hFE16, 16'h0000, 2'd1, 8'h6D, 16'h0000, 0, "");
      run_cmd(10, 16'hFE15, 16'h0, 2'd1, 8'h0, 16'h0, 0, "");
      run_cmd(9, 16'hFE16, 16'h0, 2'd1, 8'h0, 16'h0, 0, "");
      run_cmd(7, 16'hFE18, 16'h0, 2'd1, 8'h0, 16'h0, 0, "");
      run_cmd(8, 16'hFE1B, 16'h0, 2'd1, 8'h0, 16'h0, 0, "");
      run_cmd(6, 16'hFE1E, 16'h0, 2'd1, 8'h0, 16'h0, 0, "");
      run_cmd(2, 16'h0001, 16'hFFFF, 2'd1, 8'hFF, 16'h0, 0, "R12");
      run_cmd(7, 16'hFFFE, 16'h0, 2'd1, 8'h0, 16'h0, 0, "R12");
      run_cmd(4, 16'h0000, 16'h0, 2'd1, 8'h0, 16'h1357, 0, "R12");
      run_cmd(4, 16'h8000, 16'h0, 2'd1, 8'h00, 16'h2468, 1, "");
      run_cmd(3, 16'h7000, 16'hABCD, 2'd1, 8'h7F, 16'h0, 1, "");
      try_bad(4'd0);
      try_bad(4'd11);
      try_bad(4'd15);

      for (int i = 0; i < 300; i++) begin
         int c;
         c = 1 + int'($urandom(seed) % 10);
         seed = seed + 32'd977;
         run_cmd(c, 16'($urandom), 16'($urandom), 2'(1 + $urandom % 3),
                 8'($urandom), 16'($urandom), ($urandom % 8) == 0, "");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule